// File: doc/BRIEF.md
# Six-Instruction Multicycle Processor

This block is a small stored-program processor. A finite-state controller steps every instruction through fetch, decode and execute states and drives a 16-bit datapath. The datapath holds a program counter, an instruction register, sixteen 16-bit general registers with two read ports and one write port, a 256-word data store and a three-function ALU. The instruction set has six operations: load from the data store, store to it, add, subtract, load an 8-bit constant, and a relative jump taken when a register holds zero.

The program lives in an internal 256-word instruction store. It is written through a load port, and only while reset is held. When reset is released the controller clears the PC and starts fetching at address 0. A debug port shows the PC and the instruction register, and reads any general register combinationally. The test programs use it to observe results.

Top module: `sixop_cpu`

## Requirements
- R1: While `rst` is high, PC, IR and all sixteen registers read zero. After release, the PC is 0 at the end of the first cycle (Init). At the end of the second cycle (Fetch), PC = 1 and IR = I[0]. At the end of the third cycle (Decode), PC = 1 and IR = I[0] still.
- R2: An instruction word is split into fields as follows. Bits [15:12] are the opcode and bits [11:8] are register ra. Bits [7:0] are the data address, the constant or the jump offset. For add and subtract, bits [7:4] are rb and bits [3:0] are rc. Decode changes neither the PC nor the IR.
- R3: Opcode 0000 writes RF[ra] = D[bits 7:0]. Opcode 0001 writes D[bits 7:0] = RF[ra].
- R4: Opcode 0010 writes RF[ra] = RF[rb] + RF[rc]. Opcode 0100 writes RF[ra] = RF[rb] − RF[rc]. Both results wrap modulo 2^16.
- R5: Opcode 0011 writes RF[ra] = bits [7:0], zero-extended to 16 bits.
- R6: Opcode 0101 with RF[ra] == 0 spends one extra cycle to load the PC. The new PC is the jump's own address plus the sign-extended 8-bit offset. An offset of 0 jumps to itself and 0xFD jumps back three words.
- R7: Opcode 0101 with RF[ra] != 0 does not jump. The next instruction in sequence runs.
- R8: Opcodes 0110 to 1111 change no register or memory word. Decode sends them straight back to Fetch.
- R9: The program-load port writes I[prog_addr] = prog_data only while `rst` is high. A write attempt while the processor runs has no effect.
- R10: `dbg_rd_data` shows RF[`dbg_rd_addr`] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables program loading |
| prog_we | input | 1 | Instruction-store write strobe |
| prog_addr | input | 8 | Instruction-store write address |
| prog_data | input | 16 | Instruction word to write |
| dbg_rd_addr | input | 4 | Register index for the debug read |
| dbg_rd_data | output | 16 | Contents of the selected register |
| dbg_pc | output | 16 | Program counter |
| dbg_ir | output | 16 | Instruction register |

## Verification
Embedded assertions check the following on every cycle:
- Each Fetch advances the PC by one and captures the addressed instruction.
- Decode leaves the PC and IR untouched.
- The extra jump cycle lands on PC + offset − 1.
- A not-taken jump and an undefined opcode both return to Fetch.

The arithmetic results, the data-store round trip, and the effect of the zero test on which path the program takes can only be seen at the ports. So can the refusal of program writes while running. The bench runs a compare program and a countdown loop with a backward jump and an undefined opcode, then checks the register contents and the early PC/IR trace.

// File: rtl/sixop_pkg.sv
package sixop_pkg;
   localparam logic [3:0] OPC_LOAD  = 4'h0;
   localparam logic [3:0] OPC_STORE = 4'h1;
   localparam logic [3:0] OPC_ADD   = 4'h2;
   localparam logic [3:0] OPC_LDC   = 4'h3;
   localparam logic [3:0] OPC_SUB   = 4'h4;
   localparam logic [3:0] OPC_JZ    = 4'h5;

   localparam logic [1:0] ALU_PASS = 2'b00;
   localparam logic [1:0] ALU_ADD  = 2'b01;
   localparam logic [1:0] ALU_SUB  = 2'b10;

   localparam logic [1:0] WSEL_ALU   = 2'b00;
   localparam logic [1:0] WSEL_MEM   = 2'b01;
   localparam logic [1:0] WSEL_CONST = 2'b10;

   typedef enum logic [3:0] {
      S_INIT, S_FETCH, S_DECODE, S_LOAD, S_STORE,
      S_ADD, S_LDC, S_SUB, S_JZ, S_JUMP
   } state_t;
endpackage

// File: rtl/sixop_alu.sv
module sixop_alu #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] y
);
   import sixop_pkg::*;

   always_comb begin
      case (sel)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/sixop_regfile.sv
module sixop_regfile #(
   parameter int W  = 16,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] p_addr,
   output logic [W-1:0]  p_data,
   input  logic [AW-1:0] q_addr,
   output logic [W-1:0]  q_data,
   input  logic [AW-1:0] d_addr,
   output logic [W-1:0]  d_data
);
   localparam int DEPTH = 1 << AW;

   logic [W-1:0] regs [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   assign p_data = regs[p_addr];
   assign q_data = regs[q_addr];
   assign d_data = regs[d_addr];
endmodule

// File: rtl/sixop_ctrl.sv
module sixop_ctrl #(
   parameter int AW = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [3:0]          opcode,
   input  logic [AW-1:0]       ra,
   input  logic [AW-1:0]       rb,
   input  logic [AW-1:0]       rc,
   input  logic                p_zero,
   output sixop_pkg::state_t   state,
   output logic                pc_clr,
   output logic                pc_inc,
   output logic                pc_ld,
   output logic                ir_ld,
   output logic                rf_we,
   output logic [1:0]          wsel,
   output logic [1:0]          alu_sel,
   output logic                dm_we,
   output logic [AW-1:0]       p_addr,
   output logic [AW-1:0]       q_addr
);
   import sixop_pkg::*;

   state_t nxt;

   always_ff @(posedge clk) begin
      if (rst) state <= S_INIT;
      else     state <= nxt;
   end

   always_comb begin
      nxt = S_FETCH;
      case (state)
         S_INIT:   nxt = S_FETCH;
         S_FETCH:  nxt = S_DECODE;
         S_DECODE: begin
            case (opcode)
               OPC_LOAD:  nxt = S_LOAD;
               OPC_STORE: nxt = S_STORE;
               OPC_ADD:   nxt = S_ADD;
               OPC_LDC:   nxt = S_LDC;
               OPC_SUB:   nxt = S_SUB;
               OPC_JZ:    nxt = S_JZ;
               default:   nxt = S_FETCH;
            endcase
         end
         S_JZ:     nxt = p_zero ? S_JUMP : S_FETCH;
         default:  nxt = S_FETCH;
      endcase
   end

   always_comb begin
      pc_clr  = 1'b0;
      pc_inc  = 1'b0;
      pc_ld   = 1'b0;
      ir_ld   = 1'b0;
      rf_we   = 1'b0;
      wsel    = WSEL_ALU;
      alu_sel = ALU_PASS;
      dm_we   = 1'b0;
      p_addr  = ra;
      q_addr  = rc;
      case (state)
         S_INIT:  pc_clr = 1'b1;
         S_FETCH: begin
            ir_ld  = 1'b1;
            pc_inc = 1'b1;
         end
         S_LOAD: begin
            rf_we = 1'b1;
            wsel  = WSEL_MEM;
         end
         S_STORE: dm_we = 1'b1;
         S_ADD, S_SUB: begin
            p_addr  = rb;
            rf_we   = 1'b1;
            alu_sel = (state == S_ADD) ? ALU_ADD : ALU_SUB;
         end
         S_LDC: begin
            rf_we = 1'b1;
            wsel  = WSEL_CONST;
         end
         S_JUMP:  pc_ld = 1'b1;
         default: ;
      endcase
   end

   // R8
   undef_opcode_chk: assert property (@(posedge clk) disable iff (rst)
      (state == S_DECODE && opcode > OPC_JZ) |=> state == S_FETCH);

   // R7
   jz_fallthru_chk: assert property (@(posedge clk) disable iff (rst)
      (state == S_JZ && !p_zero) |=> state == S_FETCH);
endmodule

// File: rtl/sixop_cpu.sv
module sixop_cpu #(
   parameter int DW    = 16,
   parameter int RAW   = 4,
   parameter int MAW   = 8
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           prog_we,
   input  logic [MAW-1:0] prog_addr,
   input  logic [DW-1:0]  prog_data,
   input  logic [RAW-1:0] dbg_rd_addr,
   output logic [DW-1:0]  dbg_rd_data,
   output logic [DW-1:0]  dbg_pc,
   output logic [DW-1:0]  dbg_ir
);
   import sixop_pkg::*;

   localparam int OPW   = 4;
   localparam int IMMW  = DW - OPW - RAW;
   localparam int MDEP  = 1 << MAW;
   localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

   generate
      if (IMMW != 2 * RAW) begin : g_bad_fields
         $error("immediate field must hold exactly two register indices");
      end
      if (IMMW < MAW) begin : g_bad_addr
         $error("immediate field narrower than memory address");
      end
   endgenerate

   logic [DW-1:0] pc, ir;
   logic [DW-1:0] imem [MDEP];
   logic [DW-1:0] dmem [MDEP];

   state_t         state;
   logic           pc_clr, pc_inc, pc_ld, ir_ld, rf_we, dm_we;
   logic [1:0]     wsel, alu_sel;
   logic [RAW-1:0] p_addr, q_addr;
   logic [DW-1:0]  p_data, q_data, alu_y, rf_wdata, imem_rd, dm_rd;

   wire [OPW-1:0]  opcode = ir[DW-1 -: OPW];
   wire [RAW-1:0]  ra     = ir[IMMW +: RAW];
   wire [RAW-1:0]  rb     = ir[RAW +: RAW];
   wire [RAW-1:0]  rc     = ir[0 +: RAW];
   wire [IMMW-1:0] imm    = ir[IMMW-1:0];
   wire [MAW-1:0]  d_addr = ir[MAW-1:0];
   wire [DW-1:0]   off_ext   = {{(DW-IMMW){imm[IMMW-1]}}, imm};
   wire [DW-1:0]   const_ext = {{(DW-IMMW){1'b0}}, imm};
   wire            p_zero = (p_data == '0);

   assign imem_rd = imem[pc[MAW-1:0]];
   assign dm_rd   = dmem[d_addr];

   always_ff @(posedge clk) begin
      if (rst && prog_we) imem[prog_addr] <= prog_data;
   end

   always_ff @(posedge clk) begin
      if (dm_we) dmem[d_addr] <= p_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
         ir <= '0;
      end else begin
         if (pc_clr)      pc <= '0;
         else if (pc_inc) pc <= pc + ONE;
         else if (pc_ld)  pc <= pc + off_ext - ONE;
         if (ir_ld) ir <= imem_rd;
      end
   end

   always_comb begin
      case (wsel)
         WSEL_MEM:   rf_wdata = dm_rd;
         WSEL_CONST: rf_wdata = const_ext;
         default:    rf_wdata = alu_y;
      endcase
   end

   sixop_ctrl #(.AW(RAW)) u_ctrl (
      .clk(clk), .rst(rst), .opcode(opcode), .ra(ra), .rb(rb), .rc(rc),
      .p_zero(p_zero), .state(state), .pc_clr(pc_clr), .pc_inc(pc_inc),
      .pc_ld(pc_ld), .ir_ld(ir_ld), .rf_we(rf_we), .wsel(wsel),
      .alu_sel(alu_sel), .dm_we(dm_we), .p_addr(p_addr), .q_addr(q_addr)
   );

   sixop_regfile #(.W(DW), .AW(RAW)) u_rf (
      .clk(clk), .rst(rst), .we(rf_we), .waddr(ra), .wdata(rf_wdata),
      .p_addr(p_addr), .p_data(p_data), .q_addr(q_addr), .q_data(q_data),
      .d_addr(dbg_rd_addr), .d_data(dbg_rd_data)
   );

   sixop_alu #(.W(DW)) u_alu (
      .a(p_data), .b(q_data), .sel(alu_sel), .y(alu_y)
   );

   assign dbg_pc = pc;
   assign dbg_ir = ir;

   // R1
   fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
      state == S_FETCH |=> (pc == $past(pc) + ONE) && (ir == $past(imem_rd)));

   // R2
   decode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      state == S_DECODE |=> $stable(pc) && $stable(ir));

   // R6
   jump_target_chk: assert property (@(posedge clk) disable iff (rst)
      state == S_JUMP |=> pc == $past(pc) + $past(off_ext) - ONE);
endmodule

// File: tb/sixop_cpu_bench.sv
`timescale 1ns/100ps
module sixop_cpu_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        prog_we = 1'b0;
   logic [7:0]  prog_addr = '0;
   logic [15:0] prog_data = '0;
   logic [3:0]  dbg_rd_addr = '0;
   logic [15:0] dbg_rd_data, dbg_pc, dbg_ir;

   int n_chk  = 0;
   int n_fail = 0;
   logic [15:0] prog [32];

   always #2.5 clk = ~clk;

   sixop_cpu u_sixop_cpu (
      .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_data(prog_data), .dbg_rd_addr(dbg_rd_addr),
      .dbg_rd_data(dbg_rd_data), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_chk(input string req, input logic [3:0] r, input logic [15:0] exp);
      dbg_rd_addr = r;
      #0.5;
      chk(req, dbg_rd_data, exp);
   endtask

   task automatic load_prog(input int n);
      rst = 1'b1;
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         prog_we = 1'b1; prog_addr = 8'(i); prog_data = prog[i];
         @(negedge clk);
      end
      prog_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // compare program: D4=a, D5=b, D3 = (a==b); R5 <- D3, R6 = a+b
   task automatic build_compare(input logic [7:0] a, input logic [7:0] b);
      prog[0]  = {8'h38, a};  // R8 = a
      prog[1]  = 16'h1804;    // D4 = R8
      prog[2]  = {8'h38, b};  // R8 = b
      prog[3]  = 16'h1805;    // D5 = R8
      prog[4]  = 16'h3001;    // R0 = 1
      prog[5]  = 16'h0104;    // R1 = D4
      prog[6]  = 16'h0205;    // R2 = D5
      prog[7]  = 16'h4312;    // R3 = R1 - R2
      prog[8]  = 16'h5302;    // if R3==0 goto 10
      prog[9]  = 16'h4000;    // R0 = 0
      prog[10] = 16'h1003;    // D3 = R0
      prog[11] = 16'h0503;    // R5 = D3
      prog[12] = 16'h2612;    // R6 = R1 + R2
      prog[13] = 16'h5700;    // spin (R7 == 0)
   endtask

   task automatic run_compare(input logic [7:0] a, input logic [7:0] b, input bit trace);
      logic [15:0] eq = (a == b) ? 16'd1 : 16'd0;
      build_compare(a, b);
      load_prog(14);
      chk("R1 reset pc", dbg_pc, 16'h0);
      chk("R1 reset ir", dbg_ir, 16'h0);
      reg_chk("R1 reset reg", 4'd8, 16'h0);
      rst = 1'b0;
      if (trace) begin
         @(negedge clk); chk("R1 cycle1 pc", dbg_pc, 16'd0);
         @(negedge clk); chk("R1 cycle2 pc", dbg_pc, 16'd1);
                         chk("R1 cycle2 ir", dbg_ir, prog[0]);
         @(negedge clk); chk("R2 cycle3 pc", dbg_pc, 16'd1);
                         chk("R2 cycle3 ir", dbg_ir, prog[0]);
         @(negedge clk); reg_chk("R5 ldc after exec", 4'd8, {8'h00, a});
         @(negedge clk); chk("R1 cycle5 pc", dbg_pc, 16'd2);
                         chk("R1 cycle5 ir", dbg_ir, prog[1]);
      end
      wait_cycles(90);
      reg_chk("R3 load from D4", 4'd1, {8'h00, a});
      reg_chk("R3 store/load D3", 4'd5, eq);
      reg_chk(eq ? "R6 taken path keeps R0" : "R7 fallthrough clears R0", 4'd0, eq);
      reg_chk("R4 sub", 4'd3, 16'({8'h00, a} - {8'h00, b}));
      reg_chk("R4 add", 4'd6, 16'({8'h00, a} + {8'h00, b}));
      chk("R6 self-loop ir", dbg_ir, 16'h5700);
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      run_compare(8'd7, 8'd7, 1'b1);

      // R9: program write while running must be ignored
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 8'd13; prog_data = 16'h3955;
      @(negedge clk);
      prog_we = 1'b0;
      wait_cycles(20);
      reg_chk("R9 running write ignored", 4'd9, 16'h0);
      chk("R9 program unchanged", dbg_ir, 16'h5700);

      run_compare(8'd200, 8'd3, 1'b0);
      run_compare(8'd3, 8'd200, 1'b0);
      run_compare(8'd255, 8'd255, 1'b0);

      // countdown loop with backward jump and an undefined opcode
      prog[0] = 16'h3103;  // R1 = 3
      prog[1] = 16'h3201;  // R2 = 1
      prog[2] = 16'h3400;  // R4 = 0
      prog[3] = 16'h5104;  // if R1==0 goto 7
      prog[4] = 16'h4112;  // R1 = R1 - R2
      prog[5] = 16'h2442;  // R4 = R4 + R2
      prog[6] = 16'h50FD;  // goto 3 (R0 == 0)
      prog[7] = 16'hF1FF;  // undefined opcode
      prog[8] = 16'h392A;  // R9 = 0x2A
      prog[9] = 16'h5000;  // spin
      load_prog(10);
      rst = 1'b0;
      wait_cycles(120);
      reg_chk("R6 backward loop count", 4'd4, 16'd3);
      reg_chk("R7 loop exit value", 4'd1, 16'd0);
      reg_chk("R8 no write by undefined opcode", 4'd15, 16'd0);
      reg_chk("R8 execution continues after undefined opcode", 4'd9, 16'h002A);
      reg_chk("R10 debug read", 4'd2, 16'd1);
      chk("R6 spin ir", dbg_ir, 16'h5000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule